// File: doc/BRIEF.md
# Request Stream Protocol Checker

This block is a passive monitor that sits beside the 512-bit request stream of a PCIe requester. It never drives the stream. It follows packets through the valid/ready/last handshake, reads the request header carried in the low 128 bits of each packet's first beat, and compares what actually crosses the interface against that header and against the stream rules. The checked items are handshake continuity, data stability while stalled, Dword-keep shape, byte-enable form, payload size, 4 KB page crossing and payload length.

Each violation class has its own sticky flag, which stays set until software-free control logic pulses a clear input. Each packet that contains at least one violation produces a single-cycle nullify pulse. Downstream logic can use that pulse to drop the request instead of sending corrupted data. The header sits in Dwords 0 to 3 of the first beat, and the payload follows directly from Dword 4. Straddled packets are not handled, and the monitor corrects nothing.

Top module: `rqmon_top`

## Requirements
- R1: A beat is accepted when `rq_tvalid` and `rq_tready` are both high. A packet ends on the accepted beat with `rq_tlast` high, and the next accepted beat is the first beat of a new packet whose header is in bits [127:0].
- R2: If `rq_tvalid` is low in any cycle after an accepted non-last beat and before that packet's last beat, flag bit 0 (valid gap) is set.
- R3: If `rq_tvalid` and `rq_tready` are high and low in one cycle, and in the next cycle `rq_tvalid` is high but `rq_tdata` or `rq_tlast` differs, flag bit 1 (stability) is set. A stall with unchanged data sets nothing.
- R4: Each accepted non-last beat must have `rq_tkeep` all ones. The last beat must have a non-zero run of ones starting at bit 0. Otherwise flag bit 2 (keep) is set.
- R5: The header gives the byte address in bits [63:0] and the Dword count in bits [74:64]. The first-Dword enable is `rq_tuser[3:0]` and the last-Dword enable is `rq_tuser[7:4]`. Both enables are read on the first beat only, and their values on later beats have no effect.
- R6: Flag bit 3 (enables) is set when the first enable is non-zero and either of these holds: the count is 1 and the last enable is non-zero, or the count is at least 2 and the last enable is zero. It is also set when the count is above 2 and either enable is not a single run of ones. Counts of 1 or 2 accept non-contiguous enables.
- R7: A first enable of zero marks a zero-length write. It is legal only with a count of 1, a last enable of zero and one payload Dword. Any other zero-length form sets flag bit 3.
- R8: A count of zero, or a count above `MAX_PAYLOAD_DW`, sets flag bit 4 (size). A count equal to `MAX_PAYLOAD_DW` is legal.
- R9: If the Dword offset within the 4 KB page (address bits [11:2]) plus the count exceeds 1024, flag bit 5 (page crossing) is set. Exactly reaching the page end is legal.
- R10: At the last beat, if the number of kept Dwords in the packet differs from the count plus 4, flag bit 6 (length) is set.
- R11: Flags are sticky. They appear on the clock edge that ends the offending cycle. `err_clr` clears them, but an error detected in the same cycle as the clear still sets its flag.
- R12: `nullify` is high for exactly one cycle, starting at the edge that ends the cycle where a packet's first error is detected. Later errors in the same packet cause no further pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_clr | input | 1 | Clears the sticky flags |
| rq_tdata | input | DATA_W | Observed stream data |
| rq_tkeep | input | DATA_W/32 | Observed Dword keep |
| rq_tuser | input | 8 | Observed sideband: last enable [7:4], first enable [3:0] |
| rq_tlast | input | 1 | Observed end-of-packet marker |
| rq_tvalid | input | 1 | Observed valid |
| rq_tready | input | 1 | Observed ready |
| err_flags | output | 7 | Sticky flags: length, page, size, enables, keep, stability, gap (bit 6 down to 0) |
| nullify | output | 1 | One-cycle drop request for a faulty packet |

## Verification
Every result is a register loaded on the edge that ends the offending cycle. A header fault is therefore visible one edge after the first beat, a stall fault one edge after the changed cycle, a gap fault one edge after the idle cycle, and keep and length faults one edge after the beat that shows them. `nullify` rises on that same edge. The bench drives inputs just after a rising edge and samples outputs on the falling edge. The bench lets three edges pass after each packet before its monitor compares the queued expectation. It compares both the flag vector and the number of nullify pulses seen. For one header fault, the bench also checks that the pulse lands in the cycle directly after the first beat is captured.

// File: rtl/rqmon_pkg.sv
package rqmon_pkg;

    // Byte enables per Dword
    localparam int BE_W      = 4;
    // Header occupies this many Dwords at the start of the first beat
    localparam int HDR_DW    = 4;
    // Header field positions inside the first beat
    localparam int OFF_LSB   = 2;
    localparam int PAGE_DW_W = 10;
    localparam int CNT_LSB   = 64;

    typedef struct packed {
        logic len;
        logic page;
        logic size;
        logic be;
        logic keep;
        logic stab;
        logic gap;
    } rq_err_t;

    localparam int ERR_W = $bits(rq_err_t);

    // True when the enable is non-zero and its ones form one run
    function automatic logic be_single_run(input logic [BE_W-1:0] be);
        logic [BE_W-1:0] x;
        x = be;
        if (be == '0) return 1'b0;
        for (int i = 0; i < BE_W; i++) begin
            if (x[0] == 1'b0) x = x >> 1;
        end
        return (x & (x + BE_W'(1))) == '0;
    endfunction

endpackage

// File: rtl/rqmon_framer.sv
module rqmon_framer
    import rqmon_pkg::*;
#(
    parameter int KEEP_W = 16,
    parameter int CNT_W  = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tvalid,
    input  logic              tready,
    input  logic              tlast,
    input  logic [KEEP_W-1:0] tkeep,
    input  logic [CNT_W-1:0]  hdr_cnt,
    output logic              first_beat,
    output logic              gap_evt,
    output logic              keep_evt,
    output logic              len_evt
);

    localparam int ACC_W = CNT_W + 3;
    localparam logic [ACC_W-1:0] ACC_CAP = ACC_W'(2 ** (CNT_W + 1));

    logic             in_pkt_q;
    logic [ACC_W-1:0] acc_q;
    logic [CNT_W-1:0] cnt_q;
    logic             beat;
    logic [ACC_W-1:0] kept;
    logic [ACC_W-1:0] total;
    logic [CNT_W-1:0] cnt_now;
    logic             keep_full;
    logic             keep_prefix;

    function automatic logic [ACC_W-1:0] ones(input logic [KEEP_W-1:0] k);
        logic [ACC_W-1:0] n;
        n = '0;
        for (int i = 0; i < KEEP_W; i++) n = n + ACC_W'(k[i]);
        return n;
    endfunction

    assign beat        = tvalid && tready;
    assign first_beat  = beat && !in_pkt_q;
    assign kept        = ones(tkeep);
    assign total       = (in_pkt_q ? acc_q : '0) + kept;
    assign cnt_now     = in_pkt_q ? cnt_q : hdr_cnt;
    assign keep_full   = (tkeep == '1);
    assign keep_prefix = (tkeep != '0) && ((tkeep & (tkeep + KEEP_W'(1))) == '0);

    assign gap_evt  = in_pkt_q && !tvalid;
    assign keep_evt = beat && (tlast ? !keep_prefix : !keep_full);
    assign len_evt  = beat && tlast && (total != (ACC_W'(cnt_now) + ACC_W'(HDR_DW)));

    always_ff @(posedge clk) begin
        if (rst) begin
            in_pkt_q <= 1'b0;
            acc_q    <= '0;
            cnt_q    <= '0;
        end else if (beat) begin
            in_pkt_q <= !tlast;
            acc_q    <= (total > ACC_CAP) ? ACC_CAP : total;
            if (first_beat) cnt_q <= hdr_cnt;
        end
    end

endmodule

// File: rtl/rqmon_hold.sv
module rqmon_hold #(
    parameter int DATA_W = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tvalid,
    input  logic              tready,
    input  logic              tlast,
    input  logic [DATA_W-1:0] tdata,
    output logic              stab_evt
);

    logic              held_q;
    logic              last_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= 1'b0;
            last_q <= 1'b0;
            data_q <= '0;
        end else begin
            held_q <= tvalid && !tready;
            last_q <= tlast;
            data_q <= tdata;
        end
    end

    assign stab_evt = held_q && tvalid && ((tdata != data_q) || (tlast != last_q));

endmodule

// File: rtl/rqmon_hdr.sv
module rqmon_hdr
    import rqmon_pkg::*;
#(
    parameter int CNT_W          = 11,
    parameter int MAX_PAYLOAD_DW = 128
) (
    input  logic                 first_beat,
    input  logic [PAGE_DW_W-1:0] page_off,
    input  logic [CNT_W-1:0]     dw_cnt,
    input  logic [BE_W-1:0]      fbe,
    input  logic [BE_W-1:0]      lbe,
    output logic                 be_evt,
    output logic                 size_evt,
    output logic                 page_evt
);

    localparam int SUM_W = ((CNT_W > PAGE_DW_W) ? CNT_W : PAGE_DW_W) + 1;
    localparam logic [SUM_W-1:0] PAGE_DW = SUM_W'(2 ** PAGE_DW_W);

    logic [SUM_W-1:0] end_dw;
    logic             be_bad;
    logic             one_dw;
    logic             long_pkt;

    assign end_dw   = SUM_W'(page_off) + SUM_W'(dw_cnt);
    assign one_dw   = (dw_cnt == CNT_W'(1));
    assign long_pkt = (dw_cnt > CNT_W'(2));

    always_comb begin
        if (fbe == '0) begin
            be_bad = (lbe != '0) || !one_dw;
        end else if (one_dw) begin
            be_bad = (lbe != '0);
        end else begin
            be_bad = (lbe == '0) ||
                     (long_pkt && (!be_single_run(fbe) || !be_single_run(lbe)));
        end
    end

    assign be_evt   = first_beat && be_bad;
    assign size_evt = first_beat && ((dw_cnt == '0) || (dw_cnt > CNT_W'(MAX_PAYLOAD_DW)));
    assign page_evt = first_beat && (end_dw > PAGE_DW);

endmodule

// File: rtl/rqmon_top.sv
module rqmon_top
    import rqmon_pkg::*;
#(
    parameter int DATA_W         = 512,
    parameter int CNT_W          = 11,
    parameter int MAX_PAYLOAD_DW = 128
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     err_clr,
    input  logic [DATA_W-1:0]        rq_tdata,
    input  logic [DATA_W/32-1:0]     rq_tkeep,
    input  logic [2*BE_W-1:0]        rq_tuser,
    input  logic                     rq_tlast,
    input  logic                     rq_tvalid,
    input  logic                     rq_tready,
    output logic [ERR_W-1:0]         err_flags,
    output logic                     nullify
);

    localparam int KEEP_W = DATA_W / 32;

    rq_err_t          evt;
    logic [ERR_W-1:0] evt_v;
    logic [ERR_W-1:0] flags_q;
    logic             first_beat;
    logic             nulled_q;
    logic             nullify_q;
    logic             any_evt;
    logic             pkt_end;

    rqmon_framer #(
        .KEEP_W (KEEP_W),
        .CNT_W  (CNT_W)
    ) u_framer (
        .clk        (clk),
        .rst        (rst),
        .tvalid     (rq_tvalid),
        .tready     (rq_tready),
        .tlast      (rq_tlast),
        .tkeep      (rq_tkeep),
        .hdr_cnt    (rq_tdata[CNT_LSB +: CNT_W]),
        .first_beat (first_beat),
        .gap_evt    (evt.gap),
        .keep_evt   (evt.keep),
        .len_evt    (evt.len)
    );

    rqmon_hold #(
        .DATA_W (DATA_W)
    ) u_hold (
        .clk      (clk),
        .rst      (rst),
        .tvalid   (rq_tvalid),
        .tready   (rq_tready),
        .tlast    (rq_tlast),
        .tdata    (rq_tdata),
        .stab_evt (evt.stab)
    );

    rqmon_hdr #(
        .CNT_W          (CNT_W),
        .MAX_PAYLOAD_DW (MAX_PAYLOAD_DW)
    ) u_hdr (
        .first_beat (first_beat),
        .page_off   (rq_tdata[OFF_LSB +: PAGE_DW_W]),
        .dw_cnt     (rq_tdata[CNT_LSB +: CNT_W]),
        .fbe        (rq_tuser[BE_W-1:0]),
        .lbe        (rq_tuser[2*BE_W-1:BE_W]),
        .be_evt     (evt.be),
        .size_evt   (evt.size),
        .page_evt   (evt.page)
    );

    assign evt_v   = evt;
    assign any_evt = |evt_v;
    assign pkt_end = rq_tvalid && rq_tready && rq_tlast;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q   <= '0;
            nulled_q  <= 1'b0;
            nullify_q <= 1'b0;
        end else begin
            flags_q   <= err_clr ? evt_v : (flags_q | evt_v);
            nullify_q <= any_evt && !nulled_q;
            if (pkt_end)      nulled_q <= 1'b0;
            else if (any_evt) nulled_q <= 1'b1;
        end
    end

    assign err_flags = flags_q;
    assign nullify   = nullify_q;

endmodule

// File: rtl/rqmon_sva.sv
module rqmon_sva
    import rqmon_pkg::*;
#(
    parameter int DATA_W = 512
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 err_clr,
    input logic [DATA_W-1:0]    rq_tdata,
    input logic [DATA_W/32-1:0] rq_tkeep,
    input logic                 rq_tlast,
    input logic                 rq_tvalid,
    input logic                 rq_tready,
    input logic [ERR_W-1:0]     err_flags,
    input logic                 nullify
);

    // R2: idle cycle straight after an accepted middle beat
    p_gap_flag_r2: assert property (@(posedge clk) disable iff (rst)
        (rq_tvalid && rq_tready && !rq_tlast) ##1 !rq_tvalid |=> err_flags[0]);

    // R3: payload or last marker moved while stalled
    p_stall_change_r3: assert property (@(posedge clk) disable iff (rst)
        (rq_tvalid && !rq_tready) ##1
        (rq_tvalid && ((rq_tdata != $past(rq_tdata)) || (rq_tlast != $past(rq_tlast))))
        |=> err_flags[1]);

    // R4: a middle beat with a partial keep
    p_keep_mid_r4: assert property (@(posedge clk) disable iff (rst)
        (rq_tvalid && rq_tready && !rq_tlast && (rq_tkeep != '1)) |=> err_flags[2]);

    // R11: without a clear no flag ever falls
    p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        !err_clr |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

    // R12: a drop request always comes with a recorded cause
    p_nullify_cause_r12: assert property (@(posedge clk) disable iff (rst)
        nullify |-> (err_flags != '0));

endmodule

bind rqmon_top rqmon_sva #(.DATA_W(DATA_W)) u_sva (
    .clk       (clk),
    .rst       (rst),
    .err_clr   (err_clr),
    .rq_tdata  (rq_tdata),
    .rq_tkeep  (rq_tkeep),
    .rq_tlast  (rq_tlast),
    .rq_tvalid (rq_tvalid),
    .rq_tready (rq_tready),
    .err_flags (err_flags),
    .nullify   (nullify)
);

// File: tb/tb_rqmon_top.sv
module tb_rqmon_top;

    localparam int DATA_W  = 512;
    localparam int KEEP_W  = DATA_W / 32;
    localparam int MAX_PLD = 128;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              err_clr = 1'b0;
    logic [DATA_W-1:0] rq_tdata = '0;
    logic [KEEP_W-1:0] rq_tkeep = '0;
    logic [7:0]        rq_tuser = '0;
    logic              rq_tlast = 1'b0;
    logic              rq_tvalid = 1'b0;
    logic              rq_tready = 1'b1;
    logic [6:0]        err_flags;
    logic              nullify;

    rqmon_top #(.DATA_W(DATA_W), .CNT_W(11), .MAX_PAYLOAD_DW(MAX_PLD)) dut (
        .clk       (clk),
        .rst       (rst),
        .err_clr   (err_clr),
        .rq_tdata  (rq_tdata),
        .rq_tkeep  (rq_tkeep),
        .rq_tuser  (rq_tuser),
        .rq_tlast  (rq_tlast),
        .rq_tvalid (rq_tvalid),
        .rq_tready (rq_tready),
        .err_flags (err_flags),
        .nullify   (nullify)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic [6:0] flags;
        int         pulses;
        string      tag;
    } exp_t;

    exp_t       sb_q[$];
    event       chk_ev;
    int         n_chk = 0;
    int         n_fail = 0;
    int         cyc = 0;
    int         n_pulse = 0;
    int         last_pulse_cyc = -1;
    int         first_cyc = 0;
    logic [6:0] exp_acc = '0;

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (nullify) begin
        n_pulse        <= n_pulse + 1;
        last_pulse_cyc <= cyc;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard whenever the driver says results are due
    initial begin
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                chk(err_flags == e.flags, e.tag, "flags", int'(err_flags), int'(e.flags));
                chk(n_pulse == e.pulses, e.tag, "nullify pulses", n_pulse, e.pulses);
            end
        end
    end

    function automatic bit single_run(input logic [3:0] be);
        return be inside {4'h1, 4'h2, 4'h3, 4'h4, 4'h6, 4'h7, 4'h8, 4'hC, 4'hE, 4'hF};
    endfunction

    function automatic bit be_wrong(input int cnt, input logic [3:0] fbe, input logic [3:0] lbe);
        if (fbe == 4'h0) return (lbe != 4'h0) || (cnt != 1);
        if (cnt == 1) return lbe != 4'h0;
        if (lbe == 4'h0) return 1'b1;
        if (cnt > 2) return !single_run(fbe) || !single_run(lbe);
        return 1'b0;
    endfunction

    // Driver: sends one packet and queues the expected result
    task automatic send_pkt(input logic [63:0] addr, input int cnt, input int act,
                            input logic [3:0] fbe, input logic [3:0] lbe,
                            input int gap_at, input int stall_at, input bit stall_chg,
                            input int short_at, input bit clear, input bit junk_user,
                            input string tag);
        int         total;
        int         nb;
        int         kept_sum;
        logic [6:0] e;
        exp_t       item;
        if (clear) begin
            err_clr = 1'b1;
            @(posedge clk); #1;
            err_clr = 1'b0;
        end
        @(negedge clk);
        n_pulse = 0;
        @(posedge clk); #1;
        total    = 4 + act;
        nb       = (total + 15) / 16;
        kept_sum = 0;
        for (int b = 0; b < nb; b++) begin
            int dwn;
            dwn = (total - 16 * b > 16) ? 16 : total - 16 * b;
            rq_tkeep = (dwn == 16) ? 16'hFFFF : 16'((1 << dwn) - 1);
            if (b == short_at && b != nb - 1) rq_tkeep = 16'h7FFF;
            kept_sum += $countones(rq_tkeep);
            for (int d = 0; d < KEEP_W; d++) rq_tdata[32*d +: 32] = {8'(b), 8'(d), 16'hA5C3};
            if (b == 0) begin
                rq_tdata[63:0]  = addr;
                rq_tdata[74:64] = 11'(cnt);
                rq_tuser        = {lbe, fbe};
            end else begin
                rq_tuser = junk_user ? ~{lbe, fbe} : {lbe, fbe};
            end
            rq_tvalid = 1'b1;
            rq_tlast  = (b == nb - 1);
            if (b == stall_at) begin
                rq_tready = 1'b0;
                @(posedge clk); #1;
                if (stall_chg) rq_tdata[100] = ~rq_tdata[100];
                rq_tready = 1'b1;
            end
            @(posedge clk); #1;
            if (b == 0) first_cyc = cyc;
            if (b == gap_at) begin
                rq_tvalid = 1'b0;
                @(posedge clk); #1;
            end
        end
        rq_tvalid = 1'b0;
        rq_tlast  = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        e = '0;
        e[0] = (gap_at >= 0) && (gap_at < nb - 1);
        e[1] = (stall_at >= 0) && stall_chg;
        e[2] = (short_at >= 0) && (short_at < nb - 1);
        e[3] = be_wrong(cnt, fbe, lbe);
        e[4] = (cnt == 0) || (cnt > MAX_PLD);
        e[5] = ((int'(addr[11:2]) + cnt) > 1024);
        e[6] = (kept_sum != cnt + 4);
        exp_acc     = clear ? e : (exp_acc | e);
        item.flags  = exp_acc;
        item.pulses = (e != '0) ? 1 : 0;
        item.tag    = tag;
        sb_q.push_back(item);
        -> chk_ev;
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(err_flags == '0, "R11", "reset flags", int'(err_flags), 0);
        chk(nullify == 1'b0, "R12", "reset nullify", int'(nullify), 0);

        send_pkt(64'h1000, 8, 8, 4'hF, 4'hF, -1, -1, 0, -1, 1, 0, "R1 one-beat good");
        send_pkt(64'h2040, 40, 40, 4'hF, 4'hF, -1, 1, 0, -1, 1, 1, "R5 multi-beat stall, junk later enables");
        send_pkt(64'h2100, 12, 12, 4'hF, 4'h1, -1, -1, 0, -1, 1, 0, "R1 exactly full beat");
        send_pkt(64'h3000, 1, 1, 4'h0, 4'h0, -1, -1, 0, -1, 1, 0, "R7 legal zero-length");
        send_pkt(64'h3000, 1, 1, 4'h0, 4'h3, -1, -1, 0, -1, 1, 0, "R7 zero-length with last enable");
        send_pkt(64'h3000, 2, 2, 4'h0, 4'h0, -1, -1, 0, -1, 1, 0, "R7 zero-length with count 2");
        send_pkt(64'h3100, 2, 2, 4'h5, 4'h9, -1, -1, 0, -1, 1, 0, "R6 two Dwords sparse enables");
        send_pkt(64'h3200, 5, 5, 4'h5, 4'hF, -1, -1, 0, -1, 1, 0, "R6 long packet sparse enable");
        send_pkt(64'h3300, 1, 1, 4'hF, 4'h1, -1, -1, 0, -1, 1, 0, "R6 one Dword with last enable");
        send_pkt(64'h10000, 129, 129, 4'hF, 4'hF, -1, -1, 0, -1, 1, 0, "R8 over max payload");
        chk(last_pulse_cyc == first_cyc, "R12", "pulse cycle after header beat", last_pulse_cyc, first_cyc);
        send_pkt(64'h20000, 128, 128, 4'hF, 4'hF, -1, -1, 0, -1, 1, 0, "R8 exactly max payload");
        send_pkt(64'h0FF0, 8, 8, 4'hF, 4'hF, -1, -1, 0, -1, 1, 0, "R9 page crossing");
        send_pkt(64'h0FE0, 8, 8, 4'hF, 4'hF, -1, -1, 0, -1, 1, 0, "R9 exact page end");
        send_pkt(64'h4000, 8, 9, 4'hF, 4'hF, -1, -1, 0, -1, 1, 0, "R10 payload longer than count");
        send_pkt(64'h4000, 40, 40, 4'hF, 4'hF, 0, -1, 0, -1, 1, 0, "R2 valid gap");
        send_pkt(64'h4000, 40, 40, 4'hF, 4'hF, -1, 1, 1, -1, 1, 0, "R3 data change in stall");
        send_pkt(64'h4000, 40, 40, 4'hF, 4'hF, -1, -1, 0, 0, 1, 0, "R4 partial middle keep");
        send_pkt(64'h5000, 8, 8, 4'hF, 4'hF, -1, -1, 0, -1, 0, 0, "R11 flags held without clear");
        send_pkt(64'h5000, 8, 8, 4'hF, 4'hF, -1, -1, 0, -1, 1, 0, "R11 flags cleared");

        repeat (2) @(posedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule